// File: doc/BRIEF.md
# SPI NOR Flash Controller

This block connects one serial NOR flash device to a chip's register fabric. Software programs a 32-bit control register and a config register over a small register bus. A separate byte-wide window port carries data. Each window access is held with a request that the block acknowledges once the serial transfer has finished.

In the two read modes, a window read builds a complete flash frame. The frame sends the programmed opcode, then a 3- or 4-byte address, then a programmable number of dummy clocks, and then reads one data byte. The write mode builds the same kind of frame around one outgoing data byte.

In user mode the block turns into a byte pump driven by software. Each window write shifts one byte out on MOSI. Each window read shifts one byte in from MISO. Chip select stays asserted between accesses until software sets the stop bit, so software can frame any sequence of opcode, address and data bytes itself. Only single-bit I/O is used.

Top module: `sflash_ctrl`

## Requirements
- R1: After reset the control register reads 0x00030000, the config register reads 0, chip select is high and the serial clock is low.
- R2: The control register reads back every written bit. The config register keeps only bit 16, the write-enable, and reads 0 in every other bit.
- R3: In control mode 0 or 1 (bits 1:0), a window read drives chip select low and sends the opcode from bits 23:16. It then sends a 3-byte address, most significant byte first, and reads one data byte. The data byte is returned with the acknowledge, and chip select ends high.
- R4: Control bit 13 set makes the read address 4 bytes long. The read frame inserts D idle serial clocks before the data byte, where D = {bit 14, bit 7, bit 6}.
- R5: In mode 2 with config bit 16 set, a window write sends opcode, 3-byte address and the data byte in one chip-select frame. With bit 16 clear such a write causes no serial activity. A window read in mode 2 or a window write in modes 0/1 causes no serial activity and returns 0xFF.
- R6: In mode 3 with control bit 2 clear and config bit 16 set, each window access shifts one byte. A write sends its data byte. A read sends 0xFF and returns the captured byte. Chip select falls on the first access and stays low across later accesses.
- R7: In mode 3, when control bit 2 is set or config bit 16 is clear, window accesses produce no serial clock and leave chip select high, and reads return 0xFF. Setting bit 2 while in mode 3 raises chip select.
- R8: With T = 16 − bits 27:24, chip select stays high at least T bus clocks before it falls again. When the next request arrives within two clocks of the acknowledge, chip select falls no later than T+4 clocks after it rose.
- R9: The serial clock spends F+1 bus clocks in each half period, where F is control bits 11:8.
- R10: Control bit 4 sets the idle serial clock level to high; with the bit clear the idle level is low. Data is driven on the falling edge and sampled on the rising edge in both cases.
- R11: Control bit 5 sends and receives each byte least significant bit first.
- R12: The window acknowledge is a one-cycle pulse. Read data is valid while the acknowledge is high.
- R13: The serial clock changes only while chip select is low, apart from a change of the idle level itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 control, 1 config |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| win_req | input | 1 | Window access request, held until acknowledged |
| win_we | input | 1 | Window access is a write |
| win_addr | input | ADDR_W | Flash address for framed read/write modes |
| win_wdata | input | 8 | Window write byte |
| win_rdata | output | 8 | Window read byte, valid with win_ack |
| win_ack | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach from the ports is a user-mode transaction whose chip select stays low across several window accesses. The bytes returned there must come from the right positions in the flash's continuous response stream, including after a change of bit order or idle clock level. The bench follows the full software sequence: mode 3 with stop set, then stop cleared, then a write followed by several reads, then stop set again. A flash model keeps counting bits for as long as chip select is low, so byte positions and the chip-select framing are checked together. Dummy-clock placement is checked the same way: the model's stream offset must move by exactly the programmed count.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [1:0] {
        M_READ  = 2'd0,
        M_FAST  = 2'd1,
        M_WRITE = 2'd2,
        M_USER  = 2'd3
    } sfc_mode_e;

    // Field positions are what software decodes, so they are fixed.
    typedef struct packed {
        logic [3:0] rsvd_hi;     // 31:28
        logic [3:0] gap_sel;     // 27:24
        logic [7:0] opcode;      // 23:16
        logic       rsvd15;      // 15
        logic       dummy_hi;    // 14
        logic       addr4;       // 13
        logic       rsvd12;      // 12
        logic [3:0] fsel;        // 11:8
        logic [1:0] dummy_lo;    // 7:6
        logic       lsb_first;   // 5
        logic       idle_high;   // 4
        logic       rsvd3;       // 3
        logic       cs_stop;     // 2
        sfc_mode_e  mode;        // 1:0
    } sfc_ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE, S_GAP, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_ACK
    } sfc_state_e;

    localparam logic [31:0] CTRL_RESET = 32'h0003_0000;
    localparam int          CFG_WE_BIT = 16;
    localparam logic [4:0]  GAP_SAT    = 5'd31;

    function automatic logic [4:0] gap_min(input logic [3:0] sel);
        return 5'd16 - {1'b0, sel};
    endfunction

    function automatic logic [3:0] dummy_count(input sfc_ctrl_t c);
        return {1'b0, c.dummy_hi, c.dummy_lo};
    endfunction

    function automatic logic [4:0] half_len(input logic [3:0] f);
        return {1'b0, f} + 5'd1;
    endfunction

endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
    import sfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output sfc_ctrl_t   ctrl,
    output logic        cfg_we
);
    logic [31:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            cfg_we <= 1'b0;
        end else if (reg_we) begin
            if (reg_sel) cfg_we <= reg_wdata[CFG_WE_BIT];
            else         ctrl_q <= reg_wdata;
        end
    end

    assign ctrl = sfc_ctrl_t'(ctrl_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) reg_rdata[CFG_WE_BIT] = cfg_we;
        else         reg_rdata = ctrl_q;
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(cfg_we) && $stable(ctrl_q));
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic [3:0] nbits,
    input  logic       lsb,
    input  logic       idle_high,
    input  logic [4:0] half,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    logic       act, ph, sck_q;
    logic [4:0] cnt;
    logic [3:0] left;
    logic [7:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0; ph <= 1'b0; sck_q <= 1'b0; cnt <= '0;
            left <= '0; sh <= '0; rx <= '0; mosi <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!act) begin
                if (start) begin
                    act   <= 1'b1;
                    ph    <= 1'b0;
                    cnt   <= '0;
                    left  <= nbits;
                    sh    <= tx;
                    mosi  <= lsb ? tx[0] : tx[7];
                    sck_q <= 1'b0;
                end
            end else if (cnt == half - 5'd1) begin
                cnt <= '0;
                if (!ph) begin
                    ph    <= 1'b1;
                    sck_q <= 1'b1;
                    rx    <= lsb ? {miso, rx[7:1]} : {rx[6:0], miso};
                end else begin
                    ph <= 1'b0;
                    if (left == 4'd1) begin
                        act  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        left  <= left - 4'd1;
                        sck_q <= 1'b0;
                        sh    <= lsb ? (sh >> 1) : (sh << 1);
                        mosi  <= lsb ? sh[1] : sh[6];
                    end
                end
            end else begin
                cnt <= cnt + 5'd1;
            end
        end
    end

    assign sck = act ? sck_q : idle_high;

    // R9
    half_len_chk: assert property (@(posedge clk) disable iff (rst)
        (act && $past(act) && ($past(cnt) != $past(half) - 5'd1)) |-> $stable(sck_q));

    // R10
    edge_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (act && $rose(sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sfc_ctrl_t   ctrl,
    input  logic        cfg_we,
    input  logic        win_req,
    input  logic        win_we,
    input  logic [31:0] win_addr,
    input  logic [7:0]  win_wdata,
    input  logic        sh_done,
    input  logic [7:0]  sh_rx,
    output logic        sh_start,
    output logic [7:0]  sh_tx,
    output logic [3:0]  sh_nbits,
    output logic        cs_n,
    output logic        win_ack,
    output logic [7:0]  win_rdata
);
    sfc_state_e  st;
    sfc_mode_e   fr_mode;
    logic        fr_we, launched, drop;
    logic [31:0] fr_addr;
    logic [7:0]  fr_data;
    logic [1:0]  idx;
    logic [4:0]  gap_cnt;
    logic [3:0]  dcount;

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^{ctrl.rsvd_hi, ctrl.rsvd15, ctrl.rsvd12,
                                ctrl.rsvd3, ctrl.fsel, ctrl.lsb_first, ctrl.idle_high};

    assign dcount = dummy_count(ctrl);

    always_comb begin
        unique case (ctrl.mode)
            M_USER:  drop = ctrl.cs_stop || !cfg_we;
            M_WRITE: drop = !win_we || !cfg_we;
            default: drop = win_we;
        endcase
    end

    always_comb begin
        sh_start = !launched &&
                   (st == S_CMD || st == S_ADDR || st == S_DUMMY || st == S_DATA);
        sh_nbits = (st == S_DUMMY) ? dcount : 4'd8;
        unique case (st)
            S_CMD:   sh_tx = ctrl.opcode;
            S_ADDR:  sh_tx = fr_addr[idx*8 +: 8];
            S_DATA:  sh_tx = fr_we ? fr_data : 8'hFF;
            default: sh_tx = 8'hFF;
        endcase
    end

    assign win_ack = (st == S_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; fr_mode <= M_READ; fr_we <= 1'b0; launched <= 1'b0;
            fr_addr <= '0; fr_data <= '0; idx <= '0; cs_n <= 1'b1;
            gap_cnt <= GAP_SAT; win_rdata <= '0;
        end else begin
            if (!cs_n) gap_cnt <= '0;
            else if (gap_cnt != GAP_SAT) gap_cnt <= gap_cnt + 5'd1;

            if (sh_start) launched <= 1'b1;
            else if (sh_done) launched <= 1'b0;

            unique case (st)
                S_IDLE: begin
                    if (ctrl.mode != M_USER || ctrl.cs_stop) cs_n <= 1'b1;
                    if (win_req) begin
                        fr_mode <= ctrl.mode;
                        fr_we   <= win_we;
                        fr_addr <= win_addr;
                        fr_data <= win_wdata;
                        if (drop) begin
                            win_rdata <= 8'hFF;
                            st        <= S_ACK;
                        end else if (ctrl.mode == M_USER && !cs_n) begin
                            st <= S_DATA;
                        end else begin
                            st <= S_GAP;
                        end
                    end
                end
                S_GAP: if (gap_cnt >= gap_min(ctrl.gap_sel)) begin
                    cs_n <= 1'b0;
                    st   <= (fr_mode == M_USER) ? S_DATA : S_CMD;
                end
                S_CMD: if (sh_done) begin
                    idx <= ctrl.addr4 ? 2'd3 : 2'd2;
                    st  <= S_ADDR;
                end
                S_ADDR: if (sh_done) begin
                    if (idx == 2'd0) st <= (dcount != 4'd0) ? S_DUMMY : S_DATA;
                    else             idx <= idx - 2'd1;
                end
                S_DUMMY: if (sh_done) st <= S_DATA;
                S_DATA: if (sh_done) begin
                    win_rdata <= sh_rx;
                    if (fr_mode != M_USER) cs_n <= 1'b1;
                    st <= S_ACK;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        win_ack |=> !win_ack);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (gap_cnt >= gap_min(ctrl.gap_sel)));

    // R5
    we_guard_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && (fr_mode == M_WRITE || fr_mode == M_USER)) |-> cfg_we);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl.cs_stop) && ctrl.mode == M_USER && st == S_IDLE) |=> cs_n);
endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              win_req,
    input  logic              win_we,
    input  logic [ADDR_W-1:0] win_addr,
    input  logic [7:0]        win_wdata,
    output logic [7:0]        win_rdata,
    output logic              win_ack,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    sfc_ctrl_t   ctrl;
    logic        cfg_we, sh_start, sh_done;
    logic [7:0]  sh_tx, sh_rx;
    logic [3:0]  sh_nbits;
    logic [31:0] addr_ext;

    assign addr_ext = 32'(win_addr);

    sfc_regs u_regs (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl(ctrl), .cfg_we(cfg_we)
    );

    sfc_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .cfg_we(cfg_we),
        .win_req(win_req), .win_we(win_we), .win_addr(addr_ext),
        .win_wdata(win_wdata), .sh_done(sh_done), .sh_rx(sh_rx),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_nbits(sh_nbits),
        .cs_n(spi_cs_n), .win_ack(win_ack), .win_rdata(win_rdata)
    );

    sfc_shifter u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .nbits(sh_nbits),
        .lsb(ctrl.lsb_first), .idle_high(ctrl.idle_high), .half(half_len(ctrl.fsel)),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
    );

    // R13
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(spi_sck) && $stable(ctrl.idle_high)) |-> !spi_cs_n);
endmodule

// File: tb/sim_sflash_ctrl.sv
module sim_sflash_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0, reg_we = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        win_req = 1'b0, win_we = 1'b0;
    logic [31:0] win_addr = '0;
    logic [7:0]  win_wdata = '0, win_rdata;
    logic        win_ack, spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;

    int checks = 0, fails = 0;
    int rises = 0, cs_falls = 0, hi_edges = 0, hi_run = 0, last_hi = 0;
    int bi = 0, period = 0;
    time last_rise = 0;
    logic [7:0] resp [0:15];
    logic       wbits [0:511];

    always #10 clk = ~clk;

    sflash_ctrl u0 (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_req(win_req),
        .win_we(win_we), .win_addr(win_addr), .win_wdata(win_wdata),
        .win_rdata(win_rdata), .win_ack(win_ack), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic resp_bit(input int i);
        return resp[(i / 8) % 16][7 - (i % 8)];
    endfunction

    function automatic logic [7:0] stream_byte(input int start);
        logic [7:0] b = '0;
        for (int j = 0; j < 8; j++) b = {b[6:0], resp_bit(start + j)};
        return b;
    endfunction

    function automatic logic [7:0] wire_byte(input int k);
        logic [7:0] b = '0;
        for (int j = 0; j < 8; j++) b = {b[6:0], wbits[8*k + j]};
        return b;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[j] = v[7-j];
        return r;
    endfunction

    // flash model
    always @(negedge spi_cs_n) begin
        bi = 0;
        cs_falls++;
        spi_miso = resp_bit(0);
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            wbits[bi % 512] = spi_mosi;
            bi++;
            rises++;
            period = int'(($time - last_rise) / 20);
            last_rise = $time;
            spi_miso = resp_bit(bi);
        end else begin
            hi_edges++;
        end
    end

    always @(posedge clk) begin
        if (spi_cs_n) hi_run++;
        else hi_run = 0;
    end
    always @(negedge spi_cs_n) last_hi = hi_run;

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic win(input logic we, input logic [31:0] a, input logic [7:0] d,
                       output logic [7:0] q);
        int n = 0;
        @(negedge clk);
        win_req = 1'b1; win_we = we; win_addr = a; win_wdata = d;
        while (!win_ack && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(win_ack, "R12 ack", {31'b0, win_ack}, 32'h1);
        q = win_rdata;
        win_req = 1'b0;
        @(negedge clk);
        check(!win_ack, "R12 pulse", {31'b0, win_ack}, 32'h0);
    endtask

    task automatic clr;
        rises = 0; cs_falls = 0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(spi_cs_n == 1'b1, "R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
        check(spi_sck == 1'b0, "R1 sck", {31'b0, spi_sck}, 32'h0);
        reg_read(1'b0, v); check(v == 32'h0003_0000, "R1 ctrl", v, 32'h0003_0000);
        reg_read(1'b1, v); check(v == 32'h0, "R1 cfg", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        reg_write(1'b0, 32'hA5B6_C7F4);
        reg_read(1'b0, v); check(v == 32'hA5B6_C7F4, "R2 ctrl", v, 32'hA5B6_C7F4);
        reg_write(1'b1, 32'hFFFF_FFFF);
        reg_read(1'b1, v); check(v == 32'h0001_0000, "R2 cfg", v, 32'h0001_0000);
        reg_write(1'b1, 32'h0);
        reg_write(1'b0, 32'h0003_0000);
    endtask

    task automatic t_read3;
        logic [7:0] q;
        clr;
        win(1'b0, 32'h0012_3456, 8'h00, q);
        check(wire_byte(0) == 8'h03, "R3 opcode", wire_byte(0), 8'h03);
        check({wire_byte(1), wire_byte(2), wire_byte(3)} == 24'h123456, "R3 addr",
              {wire_byte(1), wire_byte(2), wire_byte(3)}, 24'h123456);
        check(rises == 40, "R3 clocks", rises, 40);
        check(q == resp[4], "R3 data", q, resp[4]);
        check(spi_cs_n && cs_falls == 1, "R3 frame", cs_falls, 1);
        check(period == 2, "R9 div0", period, 2);
    endtask

    task automatic t_read4;
        logic [7:0] q;
        reg_write(1'b0, 32'h000B_6041);
        clr;
        win(1'b0, 32'hA1B2_C3D4, 8'h00, q);
        check(wire_byte(0) == 8'h0B, "R4 opcode", wire_byte(0), 8'h0B);
        check({wire_byte(1), wire_byte(2), wire_byte(3), wire_byte(4)} == 32'hA1B2C3D4,
              "R4 addr", {wire_byte(1), wire_byte(2), wire_byte(3), wire_byte(4)}, 32'hA1B2C3D4);
        check(rises == 53, "R4 clocks", rises, 53);
        check(q == stream_byte(45), "R4 dummy data", q, stream_byte(45));
        reg_write(1'b0, 32'h0003_0000);
    endtask

    task automatic t_gap;
        logic [7:0] q;
        win(1'b0, 32'h0, 8'h0, q);
        win(1'b0, 32'h4, 8'h0, q);
        check(last_hi >= 16, "R8 min16", last_hi, 16);
        reg_write(1'b0, 32'h0F03_0000);
        win(1'b0, 32'h0, 8'h0, q);
        win(1'b0, 32'h4, 8'h0, q);
        check(last_hi >= 1 && last_hi <= 5, "R8 min1", last_hi, 5);
        reg_write(1'b0, 32'h0003_0000);
    endtask

    task automatic t_write;
        logic [7:0] q;
        reg_write(1'b1, 32'h0001_0000);
        reg_write(1'b0, 32'h0002_0002);
        clr;
        win(1'b1, 32'h0000_0100, 8'h5A, q);
        check({wire_byte(0), wire_byte(1), wire_byte(2), wire_byte(3), wire_byte(4)} == 40'h020001005A,
              "R5 frame", {wire_byte(0), wire_byte(3), wire_byte(4)}, 24'h02005A);
        check(rises == 40 && spi_cs_n, "R5 clocks", rises, 40);
        clr;
        win(1'b0, 32'h0, 8'h0, q);
        check(q == 8'hFF && rises == 0, "R5 read drop", {24'b0, q}, 32'hFF);
        reg_write(1'b1, 32'h0);
        clr;
        win(1'b1, 32'h0000_0100, 8'h5A, q);
        check(rises == 0 && cs_falls == 0, "R5 no we", rises, 0);
        reg_write(1'b0, 32'h0003_0000);
        clr;
        win(1'b1, 32'h0, 8'h11, q);
        check(rises == 0 && q == 8'hFF, "R5 write in read mode", rises, 0);
    endtask

    task automatic t_user;
        logic [7:0] q;
        reg_write(1'b1, 32'h0001_0000);
        reg_write(1'b0, 32'h0003_0007);
        reg_write(1'b0, 32'h0003_0003);
        clr;
        check(spi_cs_n == 1'b1, "R6 cs idle", {31'b0, spi_cs_n}, 32'h1);
        win(1'b1, 32'h0, 8'h9F, q);
        check(spi_cs_n == 1'b0, "R6 cs held", {31'b0, spi_cs_n}, 32'h0);
        for (int k = 1; k <= 3; k++) begin
            win(1'b0, 32'h0, 8'h00, q);
            check(q == resp[k], "R6 read", q, resp[k]);
        end
        check(wire_byte(0) == 8'h9F && wire_byte(1) == 8'hFF, "R6 mosi",
              {wire_byte(0), wire_byte(1)}, 16'h9FFF);
        check(cs_falls == 1 && rises == 32, "R6 one frame", cs_falls, 1);
        reg_write(1'b0, 32'h0003_0007);
        repeat (2) @(negedge clk);
        check(spi_cs_n == 1'b1, "R7 stop release", {31'b0, spi_cs_n}, 32'h1);
        clr;
        win(1'b1, 32'h0, 8'h06, q);
        win(1'b0, 32'h0, 8'h00, q);
        check(rises == 0 && spi_cs_n && q == 8'hFF, "R7 stop drop", rises, 0);
        reg_write(1'b1, 32'h0);
        reg_write(1'b0, 32'h0003_0003);
        clr;
        win(1'b1, 32'h0, 8'h06, q);
        win(1'b0, 32'h0, 8'h00, q);
        check(rises == 0 && spi_cs_n && q == 8'hFF, "R7 no we", rises, 0);
        reg_write(1'b0, 32'h0003_0000);
    endtask

    task automatic t_lsb;
        logic [7:0] q;
        reg_write(1'b1, 32'h0001_0000);
        reg_write(1'b0, 32'h0003_0027);
        reg_write(1'b0, 32'h0003_0023);
        win(1'b1, 32'h0, 8'h01, q);
        check(wire_byte(0) == 8'h80, "R11 tx", wire_byte(0), 8'h80);
        win(1'b0, 32'h0, 8'h00, q);
        check(q == rev8(resp[1]), "R11 rx", q, rev8(resp[1]));
        reg_write(1'b0, 32'h0003_0027);
        reg_write(1'b0, 32'h0003_0000);
    endtask

    task automatic t_mode3;
        logic [7:0] q;
        reg_write(1'b0, 32'h0003_0017);
        repeat (2) @(negedge clk);
        check(spi_sck == 1'b1, "R10 idle high", {31'b0, spi_sck}, 32'h1);
        hi_edges = 0;
        reg_write(1'b0, 32'h0003_0013);
        win(1'b1, 32'h0, 8'hA5, q);
        check(wire_byte(0) == 8'hA5, "R10 tx", wire_byte(0), 8'hA5);
        win(1'b0, 32'h0, 8'h00, q);
        check(q == resp[1], "R10 rx", q, resp[1]);
        check(spi_sck == 1'b1, "R10 idle after", {31'b0, spi_sck}, 32'h1);
        reg_write(1'b0, 32'h0003_0017);
        reg_write(1'b0, 32'h0003_0000);
        repeat (2) @(negedge clk);
        check(spi_sck == 1'b0, "R10 idle low", {31'b0, spi_sck}, 32'h0);
    endtask

    task automatic t_div;
        logic [7:0] q;
        reg_write(1'b0, 32'h0003_0307);
        reg_write(1'b0, 32'h0003_0303);
        win(1'b1, 32'h0, 8'h3C, q);
        check(period == 8, "R9 div3", period, 8);
        check(wire_byte(0) == 8'h3C, "R9 data", wire_byte(0), 8'h3C);
        reg_write(1'b0, 32'h0003_0307);
        reg_write(1'b0, 32'h0003_0000);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) resp[k] = 8'((k * 8'h35) ^ 8'hA7);
        for (int k = 0; k < 512; k++) wbits[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_read3;
        t_read4;
        t_gap;
        t_write;
        t_user;
        t_lsb;
        t_mode3;
        t_div;
        check(hi_edges == 0, "R13 no clock outside frame", hi_edges, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule